// File: doc/BRIEF.md
# Column Single-Slope Converter Back End with Dual Digital CDS

This block is the digital half of a column-parallel single-slope converter for a sensor row that yields three samples per pixel. A single shared counter sweeps a code range once per ramp. The analog ramp follows this counter. Each column's comparator output enters the block as one bit. The block latches the counter value at the comparator's first rising edge in that ramp. Each row runs three back-to-back ramps, in this order: short-exposure signal, then reset level, then long-exposure signal. The three codes of a column go into three separate banks.

When the long ramp ends, the block streams the row out. Each column gives two correlated-double-sampling results, and both use the same reset code as the reference: reset minus short, and reset minus long. A result that would be negative is clamped to zero. The banks are split into an even-column group and an odd-column group. The output multiplexer takes words from the two groups in turn, so the columns leave in ascending order.

A new row starts with a one-cycle request pulse. Requests that arrive while a row is still converting or streaming are dropped. So the banks need no second copy.

Top module: `ss_cds_backend`

## Requirements
- R1: After reset, `busy`, `ramp_on` and `out_valid` are 0 and `ramp_cnt` is 0.
- R2: A `row_start` pulse in idle makes `ramp_on` 1 with `ramp_cnt` 0 and `ramp_sel` 0 in the next cycle. While a ramp runs, `ramp_cnt` rises by one per cycle up to 2^CW-1 (1023 by default).
- R3: Three ramps run with no gap between them: `ramp_sel` 0 (short), then 1 (reset), then 2 (long), each 2^CW cycles long. The first output word appears in the cycle after the long ramp's last count.
- R4: A column's code is the `ramp_cnt` value at the first clock edge in a ramp where its comparator bit is sampled 1 after being 0. The level before a ramp's first sample counts as 0. Later rising edges in the same ramp are ignored.
- R5: A column whose comparator never rises during a ramp gets code 2^CW-1.
- R6: A short word carries max(reset code − short code, 0). A long word carries max(reset code − long code, 0).
- R7: A stream is 2·NCOL consecutive valid cycles. First come NCOL short words (`out_long`=0) for columns 0,1,…,NCOL−1. Then come NCOL long words (`out_long`=1) in the same column order. Even columns come from the even group and odd columns from the odd group.
- R8: A `row_start` received while `busy` is 1 has no effect: the counter, the ramp order and the stream continue unchanged.
- R9: `busy` is 1 from the cycle after an accepted `row_start` through the last stream word, and 0 in the cycle after that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_start | input | 1 | One-cycle request to convert a new row |
| cmp_in | input | NCOL | Comparator output of each column |
| busy | output | 1 | Row conversion or stream-out in progress |
| ramp_on | output | 1 | A ramp is running |
| ramp_cnt | output | CW | Shared ramp counter |
| ramp_sel | output | 2 | Current sample: 0 short, 1 reset, 2 long |
| out_valid | output | 1 | Output word valid |
| out_long | output | 1 | 0: reset−short word, 1: reset−long word |
| out_col | output | $clog2(NCOL) | Column of the output word |
| out_data | output | CW | Clamped CDS difference |

## Verification
The assertions check the sequencing on every cycle:
- the counter steps by one within a ramp;
- the ramp moves short to reset to long and then into the stream;
- the column index and pass flag step through the stream, with `busy` dropping after the last word;
- a latched code does not change once its first edge has been taken.

Some behaviour only the bench scenarios can show:
- the numeric codes, including the ones taken at count 0 and at full scale;
- that glitch pulses and second edges are ignored;
- that differences clamp to zero;
- that a request arriving in the middle of a row is dropped.

// File: rtl/ss_cds_pkg.sv
package ss_cds_pkg;
   typedef enum logic [1:0] {
      SMP_SHORT = 2'd0,
      SMP_RESET = 2'd1,
      SMP_LONG  = 2'd2
   } smp_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_CONV   = 2'd1,
      ST_STREAM = 2'd2
   } st_e;
endpackage

// File: rtl/ss_ramp_seq.sv
// Shared ramp counter, sample-phase sequencing and stream indexing.
module ss_ramp_seq
   import ss_cds_pkg::*;
#(
   parameter int CW   = 10,
   parameter int NCOL = 8,
   localparam int CIW = $clog2(NCOL)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   output logic           ramp_on,
   output logic [CW-1:0]  cnt,
   output logic [1:0]     sel,
   output logic           ramp_clr,
   output logic           ramp_done,
   output logic           stream_on,
   output logic [CIW-1:0] s_col,
   output logic           s_long,
   output logic           busy
);
   localparam logic [CW-1:0]  MAXC    = '1;
   localparam logic [CIW-1:0] LASTCOL = CIW'(NCOL - 1);

   st_e            st_q;
   logic [CW-1:0]  cnt_q;
   smp_e           sel_q;
   logic [CIW-1:0] col_q;
   logic           long_q;
   logic           last_cnt;

   assign last_cnt = (cnt_q == MAXC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         sel_q  <= SMP_SHORT;
         col_q  <= '0;
         long_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q  <= ST_CONV;
                  cnt_q <= '0;
                  sel_q <= SMP_SHORT;
               end
            end
            ST_CONV: begin
               if (last_cnt) begin
                  cnt_q <= '0;
                  if (sel_q == SMP_LONG) begin
                     st_q   <= ST_STREAM;
                     col_q  <= '0;
                     long_q <= 1'b0;
                  end else begin
                     sel_q <= smp_e'(sel_q + 2'd1);
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_STREAM: begin
               if (col_q == LASTCOL) begin
                  col_q <= '0;
                  if (long_q) begin
                     st_q   <= ST_IDLE;
                     long_q <= 1'b0;
                  end else begin
                     long_q <= 1'b1;
                  end
               end else begin
                  col_q <= col_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ramp_on   = (st_q == ST_CONV);
   assign cnt       = cnt_q;
   assign sel       = sel_q;
   assign ramp_done = (st_q == ST_CONV) && last_cnt;
   assign ramp_clr  = ((st_q == ST_IDLE) && start) ||
                      ((st_q == ST_CONV) && last_cnt && (sel_q != SMP_LONG));
   assign stream_on = (st_q == ST_STREAM);
   assign s_col     = col_q;
   assign s_long    = long_q;
   assign busy      = (st_q != ST_IDLE);

   // R2: counter advances by one inside a ramp, phase held
   assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_on && cnt != MAXC) |=> (ramp_on && cnt == $past(cnt) + 1'b1 && sel == $past(sel)));

   // R3: after a non-final ramp the next phase starts at zero
   assert_phase_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_on && cnt == MAXC && sel != SMP_LONG) |=> (ramp_on && cnt == '0 && sel == $past(sel) + 2'd1));

   // R7: column index steps within a pass
   assert_stream_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_on && s_col != LASTCOL) |=> (stream_on && s_col == $past(s_col) + 1'b1 && s_long == $past(s_long)));

   // R7: short pass hands over to long pass at column 0
   assert_pass_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_on && s_col == LASTCOL && !s_long) |=> (stream_on && s_col == '0 && s_long));

   // R9: block is idle right after the final word
   assert_idle_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_on && s_col == LASTCOL && s_long) |=> (!busy && !ramp_on));
endmodule

// File: rtl/ss_col_capture.sv
// Per-column first-rising-edge counter latch.
module ss_col_capture #(
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic          cmp,
   input  logic [CW-1:0] cnt,
   output logic [CW-1:0] code
);
   localparam logic [CW-1:0] MAXC = '1;

   logic          prev_q;
   logic          got_q;
   logic [CW-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         got_q  <= 1'b0;
         lat_q  <= '0;
      end else if (clr) begin
         prev_q <= 1'b0;
         got_q  <= 1'b0;
         lat_q  <= '0;
      end else if (en) begin
         prev_q <= cmp;
         if (!got_q && cmp && !prev_q) begin
            got_q <= 1'b1;
            lat_q <= cnt;
         end
      end
   end

   // no edge in the ramp means full-scale code
   assign code = got_q ? lat_q : MAXC;

   // R4: a taken code stays frozen for the rest of the ramp
   assert_first_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && got_q && !clr) |=> (got_q && lat_q == $past(lat_q)));
endmodule

// File: rtl/ss_cds_clamp_sub.sv
// Reference minus sample, floored at zero.
module ss_cds_clamp_sub #(
   parameter int CW = 10
) (
   input  logic [CW-1:0] ref_code,
   input  logic [CW-1:0] smp_code,
   output logic [CW-1:0] diff
);
   always_comb begin
      if (ref_code >= smp_code) diff = ref_code - smp_code;
      else                      diff = '0;
   end
endmodule

// File: rtl/ss_group_bank.sv
// Short/reset/long banks for one column group plus its CDS read path.
module ss_group_bank
   import ss_cds_pkg::*;
#(
   parameter int CW   = 10,
   parameter int HALF = 4,
   localparam int HIW = (HALF > 1) ? $clog2(HALF) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [HALF*CW-1:0] wr_codes,
   input  logic [HIW-1:0]     rd_idx,
   input  logic               rd_long,
   output logic [CW-1:0]      rd_data
);
   logic [CW-1:0] bk_s [HALF];
   logic [CW-1:0] bk_r [HALF];
   logic [CW-1:0] bk_l [HALF];
   logic [CW-1:0] d_short, d_long;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < HALF; k++) begin
            bk_s[k] <= '0;
            bk_r[k] <= '0;
            bk_l[k] <= '0;
         end
      end else if (wr_en) begin
         for (int k = 0; k < HALF; k++) begin
            case (smp_e'(wr_sel))
               SMP_SHORT: bk_s[k] <= wr_codes[k*CW +: CW];
               SMP_RESET: bk_r[k] <= wr_codes[k*CW +: CW];
               SMP_LONG:  bk_l[k] <= wr_codes[k*CW +: CW];
               default: ;
            endcase
         end
      end
   end

   ss_cds_clamp_sub #(.CW(CW)) u_sub_short (
      .ref_code(bk_r[rd_idx]), .smp_code(bk_s[rd_idx]), .diff(d_short));
   ss_cds_clamp_sub #(.CW(CW)) u_sub_long (
      .ref_code(bk_r[rd_idx]), .smp_code(bk_l[rd_idx]), .diff(d_long));

   assign rd_data = rd_long ? d_long : d_short;
endmodule

// File: rtl/ss_cds_backend.sv
// Column single-slope back end: capture, three banks, dual CDS, even/odd merge.
module ss_cds_backend
   import ss_cds_pkg::*;
#(
   parameter int CW   = 10,
   parameter int NCOL = 8,
   localparam int CIW  = $clog2(NCOL),
   localparam int HALF = NCOL / 2,
   localparam int HIW  = (HALF > 1) ? $clog2(HALF) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            row_start,
   input  logic [NCOL-1:0] cmp_in,
   output logic            busy,
   output logic            ramp_on,
   output logic [CW-1:0]   ramp_cnt,
   output logic [1:0]      ramp_sel,
   output logic            out_valid,
   output logic            out_long,
   output logic [CIW-1:0]  out_col,
   output logic [CW-1:0]   out_data
);
   localparam logic [CW-1:0] MAXC = '1;

   generate
      if (NCOL < 4 || (NCOL % 2) != 0) begin : g_bad_ncol
         $error("NCOL must be even and at least 4");
      end
      if (CW < 2) begin : g_bad_cw
         $error("CW must be at least 2");
      end
   endgenerate

   logic           ramp_clr, ramp_done, stream_on, s_long;
   logic [CIW-1:0] s_col;
   logic [CW-1:0]  code [NCOL];
   logic [CW-1:0]  grp_data [2];

   ss_ramp_seq #(.CW(CW), .NCOL(NCOL)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(row_start),
      .ramp_on(ramp_on), .cnt(ramp_cnt), .sel(ramp_sel),
      .ramp_clr(ramp_clr), .ramp_done(ramp_done),
      .stream_on(stream_on), .s_col(s_col), .s_long(s_long), .busy(busy));

   generate
      for (genvar c = 0; c < NCOL; c++) begin : g_col
         ss_col_capture #(.CW(CW)) u_cap (
            .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .en(ramp_on),
            .cmp(cmp_in[c]), .cnt(ramp_cnt), .code(code[c]));
      end

      for (genvar g = 0; g < 2; g++) begin : g_grp
         logic [HALF*CW-1:0] flat;
         for (genvar k = 0; k < HALF; k++) begin : g_pack
            assign flat[k*CW +: CW] = code[2*k + g];
         end
         ss_group_bank #(.CW(CW), .HALF(HALF)) u_bank (
            .clk(clk), .rst_n(rst_n), .wr_en(ramp_done), .wr_sel(ramp_sel),
            .wr_codes(flat), .rd_idx(s_col[CIW-1:1]), .rd_long(s_long),
            .rd_data(grp_data[g]));
      end
   endgenerate

   assign out_valid = stream_on;
   assign out_long  = s_long;
   assign out_col   = s_col;
   assign out_data  = grp_data[s_col[0]];

   // R3: stream begins right after the long ramp, at column 0 short pass
   assert_stream_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_on && ramp_cnt == MAXC && ramp_sel == 2'd2) |=> (out_valid && out_col == '0 && !out_long));
endmodule

// File: tb/ss_cds_backend_bench.sv
module ss_cds_backend_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CW   = 10;
   localparam int NCOL = 8;
   localparam int CIW  = $clog2(NCOL);
   localparam int MAXC = (1 << CW) - 1;
   localparam int NEVER = 5000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            row_start = 1'b0;
   logic [NCOL-1:0] cmp_in = '0;
   logic            busy, ramp_on, out_valid, out_long;
   logic [CW-1:0]   ramp_cnt, out_data;
   logic [1:0]      ramp_sel;
   logic [CIW-1:0]  out_col;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   int t1 [3][NCOL];
   int pw [3][NCOL];
   int t2 [3][NCOL];

   ss_cds_backend #(.CW(CW), .NCOL(NCOL)) u_ss_cds_backend (
      .clk(clk), .rst_n(rst_n), .row_start(row_start), .cmp_in(cmp_in),
      .busy(busy), .ramp_on(ramp_on), .ramp_cnt(ramp_cnt), .ramp_sel(ramp_sel),
      .out_valid(out_valid), .out_long(out_long), .out_col(out_col), .out_data(out_data));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic cmp_of(int p, int c, int v);
      return (v >= t1[p][c] && v < t1[p][c] + pw[p][c]) || (v >= t2[p][c]);
   endfunction

   function automatic int exp_code(int p, int c);
      if (t1[p][c] <= MAXC) return t1[p][c];
      if (t2[p][c] <= MAXC) return t2[p][c];
      return MAXC;
   endfunction

   function automatic int cds(int r, int s);
      return (r >= s) ? r - s : 0;
   endfunction

   task automatic run_row(input bit inject, input string tag);
      int ecnt = 0;
      int esel = 0;
      int steps = 0;
      bit seq_ok = 1;
      @(negedge clk);
      row_start = 1'b1;
      @(negedge clk);
      row_start = 1'b0;
      chk(ramp_on && ramp_cnt == 0 && ramp_sel == 0 && busy, "R2 ramp start", int'(ramp_cnt), 0);
      while (!out_valid && steps < 4000) begin
         if (!ramp_on || int'(ramp_cnt) != ecnt || int'(ramp_sel) != esel) seq_ok = 0;
         for (int c = 0; c < NCOL; c++) cmp_in[c] = cmp_of(int'(ramp_sel), c, int'(ramp_cnt));
         row_start = (inject && esel == 1 && ecnt == 500);
         if (ecnt == MAXC) begin ecnt = 0; esel++; end
         else ecnt++;
         steps++;
         @(negedge clk);
      end
      row_start = 1'b0;
      cmp_in = '0;
      chk(seq_ok && steps == 3 * (MAXC + 1), {"R3 ramp sequence ", tag}, steps, 3 * (MAXC + 1));
      if (inject) chk(seq_ok, "R8 mid-row start ignored", int'(seq_ok), 1);
      for (int k = 0; k < 2 * NCOL; k++) begin
         int c = k % NCOL;
         bit lg = (k >= NCOL);
         int e = cds(exp_code(1, c), exp_code(lg ? 2 : 0, c));
         chk(out_valid && busy && out_long == lg && int'(out_col) == c,
             {"R7 stream order ", tag}, int'(out_col), c);
         chk(int'(out_data) == e, {"R6 cds value (R4/R5 codes) ", tag}, int'(out_data), e);
         @(negedge clk);
      end
      chk(!out_valid && !busy, {"R9 idle after stream ", tag}, int'(busy), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      chk(!busy && !ramp_on && !out_valid && ramp_cnt == 0, "R1 reset state", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !ramp_on && !out_valid && ramp_cnt == 0, "R1 idle after reset", int'(ramp_on), 0);

      // directed: clean steps, some differences clamp to zero
      for (int p = 0; p < 3; p++)
         for (int c = 0; c < NCOL; c++) begin
            t1[p][c] = (p == 1) ? 400 + 20 * c : 200 + 37 * c + 90 * p;
            pw[p][c] = 2000;
            t2[p][c] = NEVER;
         end
      run_row(0, "steps");

      // directed: R5 no flip, edge at count 0, edge at full scale
      for (int c = 0; c < NCOL; c++) begin
         t1[0][c] = NEVER; pw[0][c] = 1; t2[0][c] = NEVER;
         t1[1][c] = (c % 2 == 0) ? NEVER : 0; pw[1][c] = 2000; t2[1][c] = NEVER;
         t1[2][c] = (c < 4) ? MAXC : 0; pw[2][c] = 2000; t2[2][c] = NEVER;
      end
      run_row(0, "R5 fullscale");

      // directed: R4 glitches and second edges, R8 mid-row request
      for (int p = 0; p < 3; p++)
         for (int c = 0; c < NCOL; c++) begin
            t1[p][c] = 10 + 50 * c + 5 * p + ((p == 1) ? 600 : 0);
            pw[p][c] = 2;
            t2[p][c] = t1[p][c] + 7;
         end
      run_row(1, "R4 glitch");

      // random rows
      for (int r = 0; r < 10; r++) begin
         for (int p = 0; p < 3; p++)
            for (int c = 0; c < NCOL; c++) begin
               t1[p][c] = $urandom_range(0, 1100);
               pw[p][c] = $urandom_range(1, 60);
               if (t1[p][c] > MAXC || ($urandom_range(0, 1) == 0)) t2[p][c] = NEVER;
               else t2[p][c] = t1[p][c] + pw[p][c] + $urandom_range(1, 300);
               if (t1[p][c] > MAXC) t2[p][c] = NEVER;
            end
         run_row(r % 3 == 0, "random");
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule